// File: doc/BRIEF.md
# Write-Once Program Store Sequencer

This block fetches instructions for a small datapath. The program is at most sixteen 9-bit words, held in a one-time-programmable store. A free-running 4-bit program counter runs on the datapath clock. A one-hot row decoder turns the count into a single active row select. The selected word is captured into an instruction register that drives the program bus, so each word appears one clock after its address. The counter wraps, so the program repeats endlessly, and there are no branches.

Each storage cell starts at logic 1 and can only be cleared. A programming write names a row and a 9-bit clear mask. Every masked bit drops to 0 and stays at 0, and nothing can set a bit back to 1. The all-ones word is the no-operation encoding, so an unused or unprogrammed row does nothing. Rows that the program does not need are simply left untouched.

A two-state lock controller guards the programming port. In `ST_OPEN`, writes are accepted. The transition `ST_OPEN -> ST_LOCKED` is taken on the clock edge where `lock_req` is high. `ST_LOCKED` has a single transition, back to itself, and only reset returns the controller to `ST_OPEN`. Reset reinitialises the counter, the instruction register and the lock, but it never restores stored bits.

Top module: `wos_fetch_seq`

## Requirements
- R1: While `rst_n` is low, `pc_out` is 0, `instr_out` is 0x1FF (the no-operation word) and `locked` is 0.
- R2: After reset, `pc_out` rises by one on every clock edge and wraps from 15 to 0.
- R3: `row_sel` has exactly one bit set, and that bit's position equals `pc_out`.
- R4: After each clock edge, `instr_out` holds the word stored, before that edge, in the row whose index `pc_out` had before that edge.
- R5: A row that has never been written reads as 0x1FF.
- R6: A write accepted at an edge sets row `prog_row` to its old value ANDed with the inverse of `prog_mask`. Bits with a 0 in the mask keep their value, and no write returns a 0 bit to 1.
- R7: `lock_req` high at an edge sets `locked` to 1 from that edge onward until reset. A write is ignored if `locked` is 1, or if `lock_req` is high in the same cycle.
- R8: Reset leaves every stored word unchanged.
- R9: If a write targets the row being fetched at the same edge, the instruction register captures the pre-write word. The new word is seen on the next pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the datapath |
| rst_n | input | 1 | Asynchronous active-low reinitialisation |
| prog_we | input | 1 | Programming write strobe |
| prog_row | input | 4 | Row targeted by a write |
| prog_mask | input | 9 | Bits to clear in the targeted row (1 = clear) |
| lock_req | input | 1 | Request to close the programming port |
| pc_out | output | 4 | Current program counter |
| row_sel | output | 16 | One-hot row select from the decoder |
| instr_out | output | 9 | Registered instruction on the program bus |
| locked | output | 1 | High once programming is disabled |

## Verification
The assertions assume that reset is held low over the first clock edge, and that `lock_req` and `prog_we` never carry unknown values after reset. Under those conditions the counter step and the lock history are defined from the first cycle. The bench drives every input only at falling edges, with fully known values, and holds reset through the first rising edge. The expected store contents come from a bench-side model of the clear-only rule. Those contents are compared as each row comes round on the program bus.

// File: rtl/wos_pkg.sv
package wos_pkg;
    localparam int PC_W    = 4;
    localparam int INSTR_W = 9;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/wos_pc_ctr.sv
module wos_pc_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] pc_o
);
    logic [W-1:0] cnt_q;

    // Free-running counter; natural overflow gives the wrap to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + W'(1);
    end

    assign pc_o = cnt_q;
endmodule

// File: rtl/wos_row_dec.sv
module wos_row_dec #(
    parameter int AW = 4,
    localparam int N = 1 << AW
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign sel_o[i] = (addr == AW'(i));
    end
endmodule

// File: rtl/wos_cell_array.sv
module wos_cell_array #(
    parameter int W = 9,
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [N-1:0] wr_sel,
    input  logic [W-1:0] wr_mask,
    input  logic [N-1:0] rd_sel,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] gated [N];

    for (genvar r = 0; r < N; r++) begin : g_row
        // Factory-fresh state is all ones; cells are never reset.
        logic [W-1:0] row_q = '1;

        always_ff @(posedge clk) begin
            if (wr_en && wr_sel[r]) row_q <= row_q & ~wr_mask;
        end

        assign gated[r] = rd_sel[r] ? row_q : '0;
    end

    // Wired-OR style read of the single selected row.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < N; r++) rd_data = rd_data | gated[r];
    end
endmodule

// File: rtl/wos_fetch_seq.sv
module wos_fetch_seq
    import wos_pkg::*;
#(
    parameter int PC_W    = wos_pkg::PC_W,
    parameter int INSTR_W = wos_pkg::INSTR_W,
    localparam int ROWS   = 1 << PC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_row,
    input  logic [INSTR_W-1:0] prog_mask,
    input  logic               lock_req,
    output logic [PC_W-1:0]    pc_out,
    output logic [ROWS-1:0]    row_sel,
    output logic [INSTR_W-1:0] instr_out,
    output logic               locked
);
    lock_state_e        state_q, state_d;
    logic               wr_ok;
    logic [ROWS-1:0]    wr_sel;
    logic [INSTR_W-1:0] rd_word;
    logic [INSTR_W-1:0] ir_q;

    wos_pc_ctr #(.W(PC_W)) u_pc (
        .clk  (clk),
        .rst_n(rst_n),
        .pc_o (pc_out)
    );

    wos_row_dec #(.AW(PC_W)) u_rd_dec (
        .addr (pc_out),
        .sel_o(row_sel)
    );

    wos_row_dec #(.AW(PC_W)) u_wr_dec (
        .addr (prog_row),
        .sel_o(wr_sel)
    );

    wos_cell_array #(.W(INSTR_W), .N(ROWS)) u_cells (
        .clk    (clk),
        .wr_en  (wr_ok),
        .wr_sel (wr_sel),
        .wr_mask(prog_mask),
        .rd_sel (row_sel),
        .rd_data(rd_word)
    );

    // Lock controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Lock controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (lock_req) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
        endcase
    end

    // Lock controller: outputs
    always_comb begin
        wr_ok  = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            ST_OPEN:   wr_ok  = prog_we && !lock_req;
            ST_LOCKED: locked = 1'b1;
        endcase
    end

    // Instruction register; all ones is the no-operation word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '1;
        else        ir_q <= rd_word;
    end

    assign instr_out = ir_q;
endmodule

// File: rtl/wos_fetch_chk.sv
module wos_fetch_chk #(
    parameter int PC_W = 4,
    localparam int ROWS = 1 << PC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lock_req,
    input logic [PC_W-1:0] pc_out,
    input logic [ROWS-1:0] row_sel,
    input logic            locked
);
    logic hist_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> (pc_out == PC_W'($past(pc_out) + 1'b1)));

    // R3
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> ($countones(row_sel) == 1 && row_sel[pc_out]));

    // R7
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> locked);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

bind wos_fetch_seq wos_fetch_chk #(.PC_W(PC_W)) u_fetch_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_req(lock_req),
    .pc_out  (pc_out),
    .row_sel (row_sel),
    .locked  (locked)
);

// File: tb/tb_wos_fetch_seq.sv
module tb_wos_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {row[3:0], clear mask[8:0], expected row word after write[8:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd0,  9'h001, 9'h1FE},
        {4'd3,  9'h0F0, 9'h10F},
        {4'd3,  9'h100, 9'h00F},
        {4'd0,  9'h000, 9'h1FE},
        {4'd15, 9'h1FF, 9'h000},
        {4'd7,  9'h055, 9'h1AA},
        {4'd3,  9'h00F, 9'h000},
        {4'd7,  9'h0AA, 9'h100}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_we = 1'b0;
    logic [3:0] prog_row = '0;
    logic [8:0] prog_mask = '0;
    logic       lock_req = 1'b0;
    logic [3:0]  pc_out;
    logic [15:0] row_sel;
    logic [8:0]  instr_out;
    logic        locked;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [8:0] exp_mem [16];
    logic [3:0] exp_pc;
    logic [8:0] exp_ir;
    logic       exp_lock;
    logic [3:0] last_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    wos_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_row(prog_row),
        .prog_mask(prog_mask), .lock_req(lock_req), .pc_out(pc_out),
        .row_sel(row_sel), .instr_out(instr_out), .locked(locked)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives, crosses one rising edge, checks at next falling edge.
    task automatic cyc(input logic we, input logic [3:0] row, input logic [8:0] mask,
                       input logic lk, input string itag);
        prog_we = we; prog_row = row; prog_mask = mask; lock_req = lk;
        @(posedge clk);
        exp_ir = exp_mem[exp_pc];
        last_row = exp_pc;
        if (we && !exp_lock && !lk) exp_mem[row] = exp_mem[row] & ~mask;
        if (lk) exp_lock = 1'b1;
        exp_pc = exp_pc + 4'd1;
        @(negedge clk);
        chk("R2 pc", {12'd0, pc_out}, {12'd0, exp_pc});
        chk("R3 row_sel", row_sel, 16'd1 << exp_pc);
        chk({itag, " instr"}, {7'd0, instr_out}, {7'd0, exp_ir});
        chk("R7 locked", {15'd0, locked}, {15'd0, exp_lock});
        prog_we = 1'b0; lock_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc", {12'd0, pc_out}, 16'd0);
        chk("R1 instr", {7'd0, instr_out}, 16'h1FF);
        chk("R1 locked", {15'd0, locked}, 16'd0);
        rst_n = 1'b1;
        exp_pc = '0; exp_ir = '1; exp_lock = 1'b0;
    endtask

    task automatic idle(input int n, input string itag);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 9'd0, 1'b0, itag);
    endtask

    initial begin
        for (int r = 0; r < 16; r++) exp_mem[r] = 9'h1FF;
        last_row = '0;
        do_reset();
        idle(20, "R5");

        // Table of clear-mask writes, each read back when its row comes round.
        for (int v = 0; v < NVEC; v++) begin
            cyc(1'b1, VEC[v][21:18], VEC[v][17:9], 1'b0, "R4");
            do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R4"); while (last_row != VEC[v][21:18]);
            chk("R6 table", {7'd0, instr_out}, {7'd0, VEC[v][8:0]});
        end

        // R9: write to the row fetched at the same edge.
        while (exp_pc != 4'd5) cyc(1'b0, 4'd0, 9'd0, 1'b0, "R4");
        cyc(1'b1, 4'd5, 9'h003, 1'b0, "R9");
        chk("R9 old word", {7'd0, instr_out}, 16'h1FF);
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R9"); while (last_row != 4'd5);
        chk("R9 new word", {7'd0, instr_out}, 16'h1FC);

        // R7: write with lock_req in same cycle, then write while locked.
        cyc(1'b1, 4'd2, 9'h1FF, 1'b1, "R7");
        cyc(1'b1, 4'd2, 9'h1FF, 1'b0, "R7");
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R7"); while (last_row != 4'd2);
        chk("R7 row2 untouched", {7'd0, instr_out}, 16'h1FF);

        // R8: reset clears the lock but keeps the store.
        do_reset();
        idle(17, "R8");
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R8"); while (last_row != 4'd3);
        chk("R8 row3 kept", {7'd0, instr_out}, 16'h000);
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R8"); while (last_row != 4'd7);
        chk("R8 row7 kept", {7'd0, instr_out}, 16'h100);

        // R6: write after reset accepted, mask of zeros changes nothing.
        cyc(1'b1, 4'd0, 9'h000, 1'b0, "R6");
        cyc(1'b1, 4'd9, 9'h180, 1'b0, "R6");
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R6"); while (last_row != 4'd9);
        chk("R6 row9", {7'd0, instr_out}, 16'h07F);
        do cyc(1'b0, 4'd0, 9'd0, 1'b0, "R6"); while (last_row != 4'd0);
        chk("R6 row0", {7'd0, instr_out}, 16'h1FE);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule